// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block watches 32 general-purpose input pins and turns chosen activity on them into interrupt requests for a host processor. Each pin first crosses into the block's clock domain through a two-flop synchroniser. It then raises a hit either on a level, active-high or active-low, or on an edge, rising, falling or both. Every pin is configured on its own. Hits land in a status register. Edge pins can hold a hit there until software clears it; all other pins show their hit only while it lasts.

The host reaches the block over a simple 16-bit register bus. Pins 0 to 15 sit in the lower register of each pair and pins 16 to 31 in the upper one, at bit position pin mod 16. Status bits that are also enabled drive one combined interrupt line. A priority encoder names the lowest-numbered enabled pending pin, so the handler can go straight to the right source without scanning the registers. Lower-numbered pins, and therefore the whole low half, win over higher ones.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0, and `irq_o` and `pend_valid_o` are 0.
- R2: Writable configuration pairs (lower half at the first offset, upper half at +2) read back their written values: enable 0x0C/0x0E, mode 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling select 0x20/0x22, rising select 0x24/0x26. Status reads at 0x08/0x0A. Any other offset reads 0, and a write to it changes no register.
- R3: Writing a word to status offset 0x08 or 0x0A clears exactly the status bits that are 1 in the word and leaves the other bits alone.
- R4: A pin whose mode bit is 0 is level-sensitive. With polarity bit 1 its status is 1 while the pin is high; with polarity bit 0 its status is 1 while the pin is low. The status follows the pin live, whatever its hold bit is.
- R5: A pin whose mode bit is 1 is edge-sensitive. Rising select alone detects rising edges, falling select alone detects falling edges, both selects detect either edge, and no select detects nothing.
- R6: For an edge pin with hold bit 1, a detected edge keeps the status bit at 1 until software clears it. With hold bit 0, the status bit is 1 for exactly one cycle per edge.
- R7: If a hit and a software clear reach the same status bit in the same cycle, the bit ends up 1.
- R8: A change on a pin shows in status after the third rising clock edge that follows it, and not before.
- R9: `irq_o` is 1 exactly when some status bit has its enable bit set. A disabled pin still updates its status bit but does not raise `irq_o`.
- R10: When `irq_o` is 1, `pend_valid_o` is 1 and `pend_pin_o` is the lowest pin number with status and enable both 1, so any low-half pin wins over every high-half pin. When nothing is pending, `pend_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| pend_valid_o | output | 1 | Some enabled pin is pending |
| pend_pin_o | output | 5 | Lowest enabled pending pin |

## Verification
Random rounds draw a fresh configuration for every pin and a random before and after pin vector. Each round then checks status at the cycle of the change and one cycle later. This tells a held edge, which stays, apart from a transient edge, which drops, and both apart from a level, which stays for as long as the pin does. Directed cases cover the other behaviours: a partial clear mask, a hit that meets a clear in the same cycle, the exact cycle at which a change appears, and writes to unmapped offsets. Fixed pin patterns check the encoder: a pending bit exactly at the boundary between the halves, disabled but pending pins, and an empty pending set.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] pins_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            pend_valid_o,
  output logic [$clog2(2*DW)-1:0] pend_pin_o
);
  localparam int NPIN = 2 * DW;
  localparam int PW   = $clog2(NPIN);

  localparam logic [AW-1:0] A_STS = AW'(8'h08);
  localparam logic [AW-1:0] A_EN  = AW'(8'h0C);
  localparam logic [AW-1:0] A_TYP = AW'(8'h10);
  localparam logic [AW-1:0] A_LVL = AW'(8'h14);
  localparam logic [AW-1:0] A_HLD = AW'(8'h18);
  localparam logic [AW-1:0] A_FAL = AW'(8'h20);
  localparam logic [AW-1:0] A_RIS = AW'(8'h24);
  localparam logic [AW-1:0] HI    = AW'(2);

  logic [NPIN-1:0] en_q, typ_q, lvl_q, hld_q, fal_q, ris_q, sts_q;
  logic [NPIN-1:0] s1_q, s2_q, sp_q;
  logic [NPIN-1:0] clr_mask, hit, hold_eff, pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; typ_q <= '0; lvl_q <= '0; hld_q <= '0; fal_q <= '0; ris_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_EN:       en_q[DW-1:0]     <= wdata_i;
        A_EN + HI:  en_q[NPIN-1:DW]  <= wdata_i;
        A_TYP:      typ_q[DW-1:0]    <= wdata_i;
        A_TYP + HI: typ_q[NPIN-1:DW] <= wdata_i;
        A_LVL:      lvl_q[DW-1:0]    <= wdata_i;
        A_LVL + HI: lvl_q[NPIN-1:DW] <= wdata_i;
        A_HLD:      hld_q[DW-1:0]    <= wdata_i;
        A_HLD + HI: hld_q[NPIN-1:DW] <= wdata_i;
        A_FAL:      fal_q[DW-1:0]    <= wdata_i;
        A_FAL + HI: fal_q[NPIN-1:DW] <= wdata_i;
        A_RIS:      ris_q[DW-1:0]    <= wdata_i;
        A_RIS + HI: ris_q[NPIN-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; sp_q <= '0;
    end else begin
      s1_q <= pins_i; s2_q <= s1_q; sp_q <= s2_q;
    end
  end

  always_comb begin
    clr_mask = '0;
    if (wr_en_i && addr_i == A_STS)      clr_mask[DW-1:0]    = wdata_i;
    if (wr_en_i && addr_i == A_STS + HI) clr_mask[NPIN-1:DW] = wdata_i;
  end

  wire [NPIN-1:0] edge_hit = (s2_q & ~sp_q & ris_q) | (~s2_q & sp_q & fal_q);
  wire [NPIN-1:0] lvl_hit  = ~(s2_q ^ lvl_q);
  assign hit      = (typ_q & edge_hit) | (~typ_q & lvl_hit);
  assign hold_eff = typ_q & hld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (hold_eff & sts_q & ~clr_mask) | hit;
  end

  assign pending = sts_q & en_q;
  assign irq_o   = |pending;

  always_comb begin
    pend_valid_o = 1'b0;
    pend_pin_o   = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pend_valid_o = 1'b1;
        pend_pin_o   = PW'(i);
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_STS:      rdata_o = sts_q[DW-1:0];
      A_STS + HI: rdata_o = sts_q[NPIN-1:DW];
      A_EN:       rdata_o = en_q[DW-1:0];
      A_EN + HI:  rdata_o = en_q[NPIN-1:DW];
      A_TYP:      rdata_o = typ_q[DW-1:0];
      A_TYP + HI: rdata_o = typ_q[NPIN-1:DW];
      A_LVL:      rdata_o = lvl_q[DW-1:0];
      A_LVL + HI: rdata_o = lvl_q[NPIN-1:DW];
      A_HLD:      rdata_o = hld_q[DW-1:0];
      A_HLD + HI: rdata_o = hld_q[NPIN-1:DW];
      A_FAL:      rdata_o = fal_q[DW-1:0];
      A_FAL + HI: rdata_o = fal_q[NPIN-1:DW];
      A_RIS:      rdata_o = ris_q[DW-1:0];
      A_RIS + HI: rdata_o = ris_q[NPIN-1:DW];
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 32,
  parameter int PW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            pend_valid,
  input logic [PW-1:0]   pend_pin,
  input logic [NPIN-1:0] sts,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] hmask,
  input logic [NPIN-1:0] clr
);
  wire [NPIN-1:0] pend = sts & en;
  wire [NPIN-1:0] keep = hmask & ~clr & sts;

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!irq && !pend_valid);
  end

  assert_irq_matches_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == pend_valid);

  assert_pin_is_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> pend[pend_pin]);

  assert_low_half_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && pend_pin >= PW'(NPIN/2)) |-> (pend[NPIN/2-1:0] == '0));

  assert_held_bits_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(keep)) == $past(keep)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .pend_valid(pend_valid_o),
  .pend_pin(pend_pin_o), .sts(sts_q), .en(en_q), .hmask(hold_eff), .clr(clr_mask)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, pvalid;
  logic [4:0]  ppin;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pend_valid_o(pvalid), .pend_pin_o(ppin)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr32(logic [7:0] a, logic [31:0] d);
    wr(a, d[15:0]); wr(a + 8'd2, d[31:16]);
  endtask

  task automatic rd32(logic [7:0] a, output logic [31:0] d);
    addr = a;      #1 d[15:0]  = rdata;
    addr = a + 2;  #1 d[31:16] = rdata;
  endtask

  function automatic logic [5:0] first_pend(logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic chk_out(string tag, logic [31:0] sts, logic [31:0] en);
    logic [5:0] f;
    f = first_pend(sts & en);
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(sts & en)});
    chk({tag, " valid"}, {31'd0, pvalid}, {31'd0, f[5]});
    if (f[5]) chk({tag, " pin"}, {27'd0, ppin}, {27'd0, f[4:0]});
  endtask

  task automatic config_all(logic [31:0] en, typ, lvl, hld, fal, ris);
    wr32(8'h0C, en); wr32(8'h10, typ); wr32(8'h14, lvl);
    wr32(8'h18, hld); wr32(8'h20, fal); wr32(8'h24, ris);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, en, typ, lvl, hld, fal, ris, p0, p1, eh, live, hit, exp2;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 8; a < 8'h28; a += 4) begin
      rd32(8'(a), v);
      chk("R1 reset read", v, 32'd0);
    end
    chk("R1 reset irq", {30'd0, irq, pvalid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: readback and unmapped offsets
    config_all(32'h1234_5678, 32'h0F0F_F0F0, 32'hAAAA_5555, 32'h3C3C_C3C3, 32'h0001_8000, 32'hFFFF_0000);
    wr(8'h04, 16'hFFFF); wr(8'h1C, 16'hFFFF); wr(8'h28, 16'hFFFF); wr(8'h0D, 16'hFFFF);
    @(negedge clk);
    rd32(8'h0C, v); chk("R2 enable", v, 32'h1234_5678);
    rd32(8'h10, v); chk("R2 mode", v, 32'h0F0F_F0F0);
    rd32(8'h14, v); chk("R2 polarity", v, 32'hAAAA_5555);
    rd32(8'h18, v); chk("R2 hold", v, 32'h3C3C_C3C3);
    rd32(8'h20, v); chk("R2 fall", v, 32'h0001_8000);
    rd32(8'h24, v); chk("R2 rise", v, 32'hFFFF_0000);
    rd32(8'h04, v); chk("R2 unmapped 04", v, 32'd0);
    rd32(8'h1C, v); chk("R2 unmapped 1C", v, 32'd0);
    rd32(8'h28, v); chk("R2 unmapped 28", v, 32'd0);

    // R8: latency, level active-high pin 5
    config_all(32'h0000_0020, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0);
    repeat (4) @(negedge clk);
    pins = 32'h0000_0020;
    repeat (2) @(posedge clk); @(negedge clk);
    rd32(8'h08, v); chk("R8 not yet after 2 edges", v & 32'h20, 32'd0);
    @(negedge clk);
    rd32(8'h08, v); chk("R8 visible after 3 edges", v & 32'h20, 32'h20);
    chk_out("R9 single pin", v, 32'h20);

    // R3: partial clear, all pins edge-held rising, disabled
    config_all(32'd0, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'd0;
    repeat (4) @(negedge clk);
    wr32(8'h08, 32'hFFFF_FFFF);
    pins = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rd32(8'h08, v); chk("R6 all held", v, 32'hFFFF_FFFF);
    chk("R9 disabled no irq", {31'd0, irq}, 32'd0);
    wr(8'h08, 16'h00F0);
    rd32(8'h08, v); chk("R3 partial clear", v, 32'hFFFF_FF0F);
    wr(8'h0A, 16'h8001);
    rd32(8'h08, v); chk("R3 upper clear", v, 32'h7FFE_FF0F);

    // R7: hit beats clear in the same cycle (pin 0)
    wr32(8'h08, 32'hFFFF_FFFF);
    pins = 32'd0;
    repeat (4) @(negedge clk);
    wr32(8'h08, 32'hFFFF_FFFF);
    pins = 32'd1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h08; wdata = 16'h0001; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd32(8'h08, v); chk("R7 set wins", v & 32'd1, 32'd1);
    wr(8'h08, 16'h0001);
    rd32(8'h08, v); chk("R3 clear later", v & 32'd1, 32'd0);

    // R10: encoder priority with level active-high pins
    config_all(32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0);
    pins = 32'h8001_0000; repeat (4) @(negedge clk);
    rd32(8'h08, v); chk("R4 live high", v, 32'h8001_0000);
    chk_out("R10 boundary 16", v, 32'hFFFF_FFFF);
    chk("R10 pin16", {27'd0, ppin}, 32'd16);
    pins = 32'h0001_8000; repeat (4) @(negedge clk);
    chk("R10 low half wins", {27'd0, ppin}, 32'd15);
    pins = 32'd0; repeat (4) @(negedge clk);
    chk("R10 none pending", {30'd0, irq, pvalid}, 32'd0);
    wr32(8'h0C, 32'h0000_0002);
    pins = 32'h0000_0003; repeat (4) @(negedge clk);
    rd32(8'h08, v); chk("R9 disabled pin still sets status", v, 32'h3);
    chk("R10 masked encoder", {27'd0, ppin}, 32'd1);
    wr32(8'h0C, 32'd0);
    @(negedge clk);
    chk("R9 no enable no irq", {31'd0, irq}, 32'd0);

    // Random rounds: R4 R5 R6 R9 R10
    for (int it = 0; it < 60; it++) begin
      en = $urandom; typ = $urandom; lvl = $urandom; hld = $urandom;
      fal = $urandom; ris = $urandom; p0 = $urandom; p1 = $urandom;
      @(negedge clk); pins = p0;
      config_all(en, typ, lvl, hld, fal, ris);
      repeat (4) @(negedge clk);
      wr32(8'h08, 32'hFFFF_FFFF);
      pins = p1;
      eh   = ((p1 & ~p0) & ris) | ((~p1 & p0) & fal);
      live = ~(p1 ^ lvl);
      hit  = (typ & eh) | (~typ & live);
      repeat (3) @(posedge clk); @(negedge clk);
      rd32(8'h08, v); chk("R5 edge/level hit", v, hit);
      chk_out("R10 random", hit, en);
      exp2 = (typ & hld & eh) | (~typ & live);
      @(negedge clk);
      rd32(8'h08, v); chk("R6 hold vs pulse", v, exp2);
      chk_out("R9 random", exp2, en);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule